// File: doc/BRIEF.md
# Streaming PRBS Pattern Generator

This block is a test-data source for links and datapaths. It emits one parallel data beat per accepted transfer on a valid/ready stream. Each beat carries one of four pseudo-random binary sequences, an alternating-bit pattern, or a repeating low-frequency word. A small word-addressed register port selects the pattern, starts and stops generation, and can inject a single bit error into the stream. It can also send a programmable preamble word a counted number of times before the pattern begins.

Generation starts a fixed number of cycles after the enable bit is written. While the generator runs, only the enable and error-inject registers accept writes. The configuration therefore stays frozen for the whole run. The beat width is 32 or 40 bits. The low-frequency pattern runs with either an 8-bit or a 10-bit word.

Top module: `prbs_stream_gen`

## Requirements
- R1: After reset, `src_valid` is 0 and every register reads back as zero.
- R2: If a write of 1 to the enable register (offset 0, bit 0) is sampled at clock edge N, `src_valid` stays low through edge N+2 and is high after edge N+3. If a write of 0 is sampled at edge N, `src_valid` stays as it was for one more cycle and is low after edge N+1.
- R3: Pattern select (offset 1) is one-hot. Value 0x01 gives a degree-7 sequence with feedback taps 7 and 6. 0x02 gives degree 15 with taps 15 and 14. 0x04 gives degree 23 with taps 23 and 18. 0x08 gives degree 31 with taps 31 and 28. Each generated bit is the XOR of the bits produced L and T positions earlier, where L is the degree and T is the second tap. The first L history bits are all ones at every start. Bit i of a beat is the i-th bit generated for that beat.
- R4: Select 0x10 makes every beat carry 1 in each odd bit position and 0 in each even one.
- R5: Select 0x20 produces a continuous bit stream, placed LSB first across beats. The stream is WORD_W/2 ones followed by WORD_W/2 zeros, repeated. It restarts at the start of the ones at every start. With 8-bit words and 32-bit beats, every beat is 0x0F0F0F0F.
- R6: While `src_valid` is high and `src_ready` is low, `src_valid` and `src_data` hold. The stream advances exactly one beat per accepted transfer.
- R7: Preamble control (offset 3) has an enable in bit 0 and a repeat count in bits 15:8. If both the enable and a nonzero count are set at start, the first `count` beats carry the preamble word and the pattern follows. A count of 0 sends no preamble.
- R8: The preamble word takes its bits 31:0 from offset 4 and its bits 39:32 from offset 5 bits 7:0. With a 32-bit beat, writes to offset 5 are ignored, offset 5 reads zero, and the preamble beat equals offset 4.
- R9: While enabled, writes to offsets 1, 3, 4 and 5 have no effect. Writes to offsets 0 and 2 still apply.
- R10: Offset 2 holds the inject bit (bit 0). Suppose a write of 1 is sampled at edge N while enabled. The bit reads 1 after edge N and 0 after edge N+1. The beat presented after edge N+3 has bit 0 inverted. That inversion stays on that beat while it is stalled, and applies to no later beat.
- R11: Reserved bits read as zero. Offsets 6 and 7 read zero. Offset 1 keeps bits 5:0, and offset 3 keeps bits 15:8 and bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| src_valid | output | 1 | Beat valid |
| src_ready | input | 1 | Sink ready; transfer when both are high |
| src_data | output | DATA_W | Beat data |

## Verification
The bench compares every cycle against a bit-serial model. It covers all four sequences and both constant patterns, and it uses random backpressure. A generator that advanced on stalls, or that carried the sequence over from a previous run instead of reseeding, would mismatch within a few beats. The bench targets several boundary cases: the exact first-valid cycle, the one-cycle drain after disable, a preamble count of zero against a count of three, and an error injection that lands on a stalled beat. A wrong latency, a missing or extra preamble beat, or a flip that lingered or hit the wrong beat would each show up as a data or valid mismatch. Locked writes issued mid-run are read back. A second, 32-bit instance shows that the upper preamble register is dropped there.

// File: rtl/prbs_gen_pkg.sv
`timescale 1ns/1ps
package prbs_gen_pkg;

    localparam int LFSR_W = 31;
    localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

    localparam logic [2:0] ADDR_EN   = 3'd0;
    localparam logic [2:0] ADDR_SEL  = 3'd1;
    localparam logic [2:0] ADDR_INJ  = 3'd2;
    localparam logic [2:0] ADDR_PCTL = 3'd3;
    localparam logic [2:0] ADDR_PLO  = 3'd4;
    localparam logic [2:0] ADDR_PHI  = 3'd5;

    typedef enum logic [1:0] {PK_NONE, PK_PRBS, PK_HF, PK_LF} pat_kind_e;

    typedef struct packed {
        pat_kind_e  kind;
        logic [4:0] len;
        logic [4:0] tap;
    } pat_cfg_t;

    function automatic pat_cfg_t decode_sel(input logic [5:0] sel);
        pat_cfg_t c;
        c.kind = PK_NONE;
        c.len  = 5'd7;
        c.tap  = 5'd6;
        case (sel)
            6'h01: begin c.kind = PK_PRBS; c.len = 5'd7;  c.tap = 5'd6;  end
            6'h02: begin c.kind = PK_PRBS; c.len = 5'd15; c.tap = 5'd14; end
            6'h04: begin c.kind = PK_PRBS; c.len = 5'd23; c.tap = 5'd18; end
            6'h08: begin c.kind = PK_PRBS; c.len = 5'd31; c.tap = 5'd28; end
            6'h10: c.kind = PK_HF;
            6'h20: c.kind = PK_LF;
            default: c.kind = PK_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pgen_regs.sv
`timescale 1ns/1ps
module pgen_regs
    import prbs_gen_pkg::*;
#(
    parameter int DATA_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              en,
    output logic [5:0]        sel,
    output logic              inj,
    output logic              inj_fire,
    output logic              pre_en,
    output logic [7:0]        pre_cnt,
    output logic [DATA_W-1:0] pre_char
);

    localparam bit HAS_HI = (DATA_W > 32);

    typedef struct packed {
        logic        en;
        logic [5:0]  sel;
        logic        inj;
        logic        pre_en;
        logic [7:0]  pre_cnt;
        logic [31:0] lo;
        logic [7:0]  hi;
    } regs_t;

    regs_t q, d;
    logic [39:0] full_char;

    always_comb begin
        d = q;
        if (q.en && q.inj) d.inj = 1'b0;
        if (cfg_wr) begin
            case (cfg_addr)
                ADDR_EN:   d.en = cfg_wdata[0];
                ADDR_INJ:  d.inj = cfg_wdata[0];
                ADDR_SEL:  if (!q.en) d.sel = cfg_wdata[5:0];
                ADDR_PCTL: if (!q.en) begin
                    d.pre_en  = cfg_wdata[0];
                    d.pre_cnt = cfg_wdata[15:8];
                end
                ADDR_PLO:  if (!q.en) d.lo = cfg_wdata;
                ADDR_PHI:  if (!q.en && HAS_HI) d.hi = cfg_wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            ADDR_EN:   cfg_rdata[0] = q.en;
            ADDR_SEL:  cfg_rdata[5:0] = q.sel;
            ADDR_INJ:  cfg_rdata[0] = q.inj;
            ADDR_PCTL: begin
                cfg_rdata[0]    = q.pre_en;
                cfg_rdata[15:8] = q.pre_cnt;
            end
            ADDR_PLO:  cfg_rdata = q.lo;
            ADDR_PHI:  cfg_rdata[7:0] = HAS_HI ? q.hi : 8'h00;
            default: ;
        endcase
    end

    assign full_char = {q.hi, q.lo};
    assign pre_char  = full_char[DATA_W-1:0];
    assign en        = q.en;
    assign sel       = q.sel;
    assign inj       = q.inj;
    assign inj_fire  = q.en & q.inj;
    assign pre_en    = q.pre_en;
    assign pre_cnt   = q.pre_cnt;

endmodule

// File: rtl/pgen_pattern.sv
`timescale 1ns/1ps
module pgen_pattern
    import prbs_gen_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int WORD_W = 10,
    parameter int PH_W   = 4
) (
    input  logic [5:0]        sel,
    input  logic [LFSR_W-1:0] lfsr_in,
    input  logic [PH_W-1:0]   phase_in,
    output logic [DATA_W-1:0] beat,
    output logic [LFSR_W-1:0] lfsr_out,
    output logic [PH_W-1:0]   phase_out
);

    localparam logic [PH_W-1:0] HALF = PH_W'(WORD_W / 2);
    localparam logic [PH_W-1:0] LAST = PH_W'(WORD_W - 1);

    pat_cfg_t          cfg;
    logic [LFSR_W-1:0] s;
    logic [PH_W-1:0]   pos;
    logic              nb;

    always_comb begin
        cfg  = decode_sel(sel);
        s    = lfsr_in;
        pos  = phase_in;
        nb   = 1'b0;
        beat = '0;
        for (int i = 0; i < DATA_W; i++) begin
            case (cfg.kind)
                PK_PRBS: begin
                    nb      = s[cfg.len - 5'd1] ^ s[cfg.tap - 5'd1];
                    s       = {s[LFSR_W-2:0], nb};
                    beat[i] = nb;
                end
                PK_HF:   beat[i] = ((i % 2) == 1);
                PK_LF: begin
                    beat[i] = (pos < HALF);
                    pos     = (pos == LAST) ? '0 : pos + 1'b1;
                end
                default: beat[i] = 1'b0;
            endcase
        end
        lfsr_out  = s;
        phase_out = pos;
    end

endmodule

// File: rtl/pgen_seq.sv
`timescale 1ns/1ps
module pgen_seq
    import prbs_gen_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int PH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              inj_fire,
    input  logic              pre_en,
    input  logic [7:0]        pre_cnt,
    input  logic [DATA_W-1:0] pre_char,
    input  logic              src_ready,
    input  logic [DATA_W-1:0] pat_beat,
    input  logic [LFSR_W-1:0] pat_lfsr_nx,
    input  logic [PH_W-1:0]   pat_phase_nx,
    output logic [LFSR_W-1:0] pat_lfsr,
    output logic [PH_W-1:0]   pat_phase,
    output logic              src_valid,
    output logic [DATA_W-1:0] src_data
);

    localparam logic [1:0] WARM_LOAD = 2'd2;
    localparam logic [1:0] WARM_RUN  = 2'd3;

    typedef struct packed {
        logic [1:0]        warm;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [LFSR_W-1:0] lfsr;
        logic [PH_W-1:0]   phase;
        logic [7:0]        pre_left;
        logic              d1;
        logic              d2;
        logic              flip;
    } seq_t;

    seq_t q, d;
    logic load, accept;

    assign load      = en && (q.warm == WARM_LOAD);
    assign accept    = en && q.valid && src_ready;
    assign pat_lfsr  = load ? LFSR_SEED : q.lfsr;
    assign pat_phase = load ? '0 : q.phase;

    always_comb begin
        d    = q;
        d.d1 = en & inj_fire;
        d.d2 = en & q.d1;
        if (!en) begin
            d.warm     = '0;
            d.valid    = 1'b0;
            d.flip     = 1'b0;
            d.pre_left = '0;
        end else begin
            if (q.warm < WARM_LOAD) d.warm = q.warm + 2'd1;
            if (load) begin
                d.warm  = WARM_RUN;
                d.valid = 1'b1;
                if (pre_en && pre_cnt != 8'd0) begin
                    d.data     = pre_char;
                    d.pre_left = pre_cnt - 8'd1;
                    d.lfsr     = LFSR_SEED;
                    d.phase    = '0;
                end else begin
                    d.data     = pat_beat;
                    d.pre_left = '0;
                    d.lfsr     = pat_lfsr_nx;
                    d.phase    = pat_phase_nx;
                end
            end else if (accept) begin
                if (q.pre_left != 8'd0) begin
                    d.data     = pre_char;
                    d.pre_left = q.pre_left - 8'd1;
                end else begin
                    d.data  = pat_beat;
                    d.lfsr  = pat_lfsr_nx;
                    d.phase = pat_phase_nx;
                end
            end
            if (q.d2)        d.flip = 1'b1;
            else if (accept) d.flip = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.lfsr  <= LFSR_SEED;
        end else begin
            q <= d;
        end
    end

    assign src_valid = q.valid;
    assign src_data  = q.data ^ DATA_W'(q.flip);

endmodule

// File: rtl/prbs_stream_gen.sv
`timescale 1ns/1ps
module prbs_stream_gen
    import prbs_gen_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              src_valid,
    input  logic              src_ready,
    output logic [DATA_W-1:0] src_data
);

    localparam int PH_W = 4;

    logic              en_w, inj_w, inj_fire_w, pre_en_w;
    logic [5:0]        sel_w;
    logic [7:0]        pre_cnt_w;
    logic [DATA_W-1:0] pre_char_w, beat_w;
    logic [LFSR_W-1:0] lfsr_in_w, lfsr_nx_w;
    logic [PH_W-1:0]   ph_in_w, ph_nx_w;

    pgen_regs #(.DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .en(en_w), .sel(sel_w),
        .inj(inj_w), .inj_fire(inj_fire_w), .pre_en(pre_en_w),
        .pre_cnt(pre_cnt_w), .pre_char(pre_char_w)
    );

    pgen_pattern #(.DATA_W(DATA_W), .WORD_W(WORD_W), .PH_W(PH_W)) pat_i (
        .sel(sel_w), .lfsr_in(lfsr_in_w), .phase_in(ph_in_w),
        .beat(beat_w), .lfsr_out(lfsr_nx_w), .phase_out(ph_nx_w)
    );

    pgen_seq #(.DATA_W(DATA_W), .PH_W(PH_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .en(en_w), .inj_fire(inj_fire_w),
        .pre_en(pre_en_w), .pre_cnt(pre_cnt_w), .pre_char(pre_char_w),
        .src_ready(src_ready), .pat_beat(beat_w), .pat_lfsr_nx(lfsr_nx_w),
        .pat_phase_nx(ph_nx_w), .pat_lfsr(lfsr_in_w), .pat_phase(ph_in_w),
        .src_valid(src_valid), .src_data(src_data)
    );

endmodule

// File: rtl/prbs_gen_checker.sv
`timescale 1ns/1ps
module prbs_gen_checker #(
    parameter int DATA_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [2:0]        cfg_addr,
    input logic              en,
    input logic              inj,
    input logic [5:0]        sel,
    input logic              src_valid,
    input logic              src_ready,
    input logic [DATA_W-1:0] src_data
);

    // R6: a stalled beat holds (bit 0 excluded: an injected flip may land on it)
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && src_valid && !src_ready) |=> (src_valid && $stable(src_data[DATA_W-1:1])));

    // R2: output drains one cycle after the enable drops
    p_disable_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !src_valid);

    // R2: a new run shows valid only after three cycles of enable
    p_start_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_valid) |-> (en && $past(en, 3)));

    // R9: pattern select is frozen while running
    p_sel_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cfg_wr && cfg_addr == 3'd1) |=> $stable(sel));

    // R10: an armed inject bit clears itself one cycle later
    p_inj_selfclear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && inj && !(cfg_wr && cfg_addr == 3'd2)) |=> !inj);

endmodule

bind prbs_stream_gen prbs_gen_checker #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .en(en_w), .inj(inj_w), .sel(sel_w), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data)
);

// File: tb/prbs_stream_gen_tb_top.sv
`timescale 1ns/1ps
module prbs_stream_gen_tb_top;

    localparam int BW  = 40;
    localparam int LFW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rdata, rdata32;
    logic        src_valid, v32;
    logic        src_ready = 1'b1;
    logic [BW-1:0] src_data;
    logic [31:0] d32;

    always #4 clk = ~clk;

    prbs_stream_gen #(.DATA_W(BW), .WORD_W(LFW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata), .src_valid(src_valid),
        .src_ready(src_ready), .src_data(src_data)
    );

    prbs_stream_gen #(.DATA_W(32), .WORD_W(8)) dut32_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata32), .src_valid(v32),
        .src_ready(1'b1), .src_data(d32)
    );

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit cmp_on = 0;
    bit rand_rdy = 0;
    logic [15:0] rr = 16'hACE1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural model ----------------
    bit          m_en, m_inj, m_pe, m_valid, m_flip;
    logic [5:0]  m_sel;
    logic [7:0]  m_cnt;
    logic [31:0] m_lo;
    logic [7:0]  m_hi;
    logic [BW-1:0] m_data;
    int m_age, m_cd, m_pre_left;
    bit [31:0] st;
    int plen, ptap, hfc, lfp;

    function automatic bit gen_bit();
        bit b;
        case (m_sel)
            6'h01, 6'h02, 6'h04, 6'h08: begin
                b  = st[plen-1] ^ st[ptap-1];
                st = ((st << 1) | 32'(b)) & ((32'd1 << plen) - 1);
            end
            6'h10: begin b = (hfc % 2) == 1; hfc++; end
            6'h20: begin b = (lfp < LFW/2); lfp = (lfp + 1) % LFW; end
            default: b = 1'b0;
        endcase
        return b;
    endfunction

    function automatic logic [BW-1:0] next_beat();
        logic [BW-1:0] r;
        for (int i = 0; i < BW; i++) r[i] = gen_bit();
        return r;
    endfunction

    function automatic void start_stream();
        case (m_sel)
            6'h02: begin plen = 15; ptap = 14; end
            6'h04: begin plen = 23; ptap = 18; end
            6'h08: begin plen = 31; ptap = 28; end
            default: begin plen = 7; ptap = 6; end
        endcase
        st  = (32'd1 << plen) - 1;
        hfc = 0;
        lfp = 0;
    endfunction

    function automatic logic [31:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0: return {31'd0, m_en};
            3'd1: return {26'd0, m_sel};
            3'd2: return {31'd0, m_inj};
            3'd3: return {16'd0, m_cnt, 7'd0, m_pe};
            3'd4: return m_lo;
            3'd5: return {24'd0, m_hi};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_inj = 0; m_pe = 0; m_valid = 0; m_flip = 0;
            m_sel = 0; m_cnt = 0; m_lo = 0; m_hi = 0; m_data = 0;
            m_age = 0; m_cd = 0; m_pre_left = 0;
        end else begin
            bit old_en, acc;
            old_en = m_en;
            acc = m_valid && src_ready;
            if (!old_en) begin
                m_valid = 0; m_flip = 0; m_cd = 0; m_age = 0; m_pre_left = 0;
            end else begin
                m_age++;
                if (m_age == 3) begin
                    m_valid = 1;
                    start_stream();
                    if (m_pe && m_cnt != 0) begin
                        m_data = {m_hi, m_lo};
                        m_pre_left = m_cnt - 1;
                    end else begin
                        m_data = next_beat();
                    end
                end else if (m_age > 3 && acc) begin
                    if (m_pre_left > 0) begin
                        m_pre_left--;
                        m_data = {m_hi, m_lo};
                    end else begin
                        m_data = next_beat();
                    end
                end
                if (m_cd == 1) m_flip = 1;
                else if (m_age > 3 && acc) m_flip = 0;
                if (m_cd > 0) m_cd--;
                if (m_inj) begin m_inj = 0; m_cd = 2; end
            end
            if (cfg_wr) begin
                case (cfg_addr)
                    3'd0: m_en = cfg_wdata[0];
                    3'd2: m_inj = cfg_wdata[0];
                    3'd1: if (!old_en) m_sel = cfg_wdata[5:0];
                    3'd3: if (!old_en) begin m_pe = cfg_wdata[0]; m_cnt = cfg_wdata[15:8]; end
                    3'd4: if (!old_en) m_lo = cfg_wdata;
                    3'd5: if (!old_en) m_hi = cfg_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk({cur_req, " valid"}, 64'(src_valid), 64'(m_valid));
            if (m_valid)
                chk({cur_req, " data"}, 64'(src_data), 64'(m_data ^ BW'(m_flip)));
        end
        if (rand_rdy) begin
            rr = {rr[14:0], rr[15] ^ rr[13] ^ rr[12] ^ rr[10]};
            src_ready = rr[0] | rr[3];
        end else begin
            src_ready = 1'b1;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [2:0] a);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(req, 64'(rdata), 64'(m_rd(a)));
    endtask

    task automatic run_pat(input string req, input logic [5:0] sel, input bit rnd, input int cyc);
        wr(3'd1, 32'(sel));
        cur_req  = req;
        rand_rdy = rnd;
        wr(3'd0, 32'd1);
        repeat (cyc) @(negedge clk);
        wr(3'd0, 32'd0);
        repeat (3) @(negedge clk);
        rand_rdy = 0;
    endtask

    task automatic wait32();
        for (int k = 0; k < 8 && !v32; k++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 valid", 64'(src_valid), 64'd0);
        chk("R1 valid32", 64'(v32), 64'd0);
        for (int a = 0; a < 8; a++) begin
            @(negedge clk); cfg_addr = 3'(a); #1;
            chk("R1 reg", 64'(rdata), 64'd0);
        end
        cmp_on = 1;

        // R11: reserved bits read zero
        wr(3'd1, 32'hFFFF_FFFF);
        @(negedge clk); cfg_addr = 3'd1; #1; chk("R11 sel", 64'(rdata), 64'h3F);
        wr(3'd3, 32'hFFFF_FFFF);
        @(negedge clk); cfg_addr = 3'd3; #1; chk("R11 pctl", 64'(rdata), 64'hFF01);
        wr(3'd3, 32'd0);

        // R2: explicit start latency and drain
        wr(3'd1, 32'h01);
        cur_req = "R3";
        wr(3'd0, 32'd1);
        #1; chk("R2 lat0", 64'(src_valid), 64'd0);
        @(negedge clk); #1; chk("R2 lat1", 64'(src_valid), 64'd0);
        @(negedge clk); #1; chk("R2 lat2", 64'(src_valid), 64'd0);
        @(negedge clk); #1; chk("R2 lat3", 64'(src_valid), 64'd1);
        repeat (20) @(negedge clk);
        wr(3'd0, 32'd0);
        #1; chk("R2 drain0", 64'(src_valid), 64'd1);
        @(negedge clk); #1; chk("R2 drain1", 64'(src_valid), 64'd0);

        // R3 / R6: sequences, with and without backpressure
        run_pat("R3 prbs7 restart", 6'h01, 0, 15);
        run_pat("R3 prbs15 R6", 6'h02, 1, 60);
        run_pat("R3 prbs23 R6", 6'h04, 1, 60);
        run_pat("R3 prbs31 R6", 6'h08, 1, 60);
        run_pat("R3 prbs31", 6'h08, 0, 40);
        run_pat("R4 hf R6", 6'h10, 1, 30);

        // R5: low-frequency word, 10-bit on the main instance and 8-bit on the 32-bit one
        wr(3'd1, 32'h20);
        cur_req = "R5 lf R6";
        rand_rdy = 1;
        wr(3'd0, 32'd1);
        wait32();
        chk("R5 lf8 beat0", 64'(d32), 64'h0F0F0F0F);
        @(negedge clk);
        chk("R5 lf8 beat1", 64'(d32), 64'h0F0F0F0F);
        repeat (40) @(negedge clk);
        wr(3'd0, 32'd0);
        rand_rdy = 0;
        repeat (3) @(negedge clk);

        // R7 / R8: preamble of three beats
        wr(3'd4, 32'h1234_5678);
        wr(3'd5, 32'h0000_00AB);
        wr(3'd3, 32'h0000_0301);
        @(negedge clk); cfg_addr = 3'd5; #1;
        chk("R8 hi ignored at 32", 64'(rdata32), 64'd0);
        chk("R8 hi kept at 40", 64'(rdata), 64'hAB);
        run_pat("R7 preamble3 R6", 6'h02, 1, 40);
        wr(3'd0, 32'd1);
        wait32();
        chk("R8 preamble32", 64'(d32), 64'h1234_5678);
        repeat (10) @(negedge clk);
        wr(3'd0, 32'd0);
        repeat (3) @(negedge clk);
        wr(3'd3, 32'h0000_0001);
        run_pat("R7 count0", 6'h01, 0, 20);

        // R9 / R10: locking and error injection while running
        wr(3'd1, 32'h01);
        cur_req = "R9 R10";
        wr(3'd0, 32'd1);
        repeat (6) @(negedge clk);
        wr(3'd1, 32'h02);
        wr(3'd3, 32'h0000_0501);
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h0);
        rdchk("R9 sel locked", 3'd1);
        chk("R9 sel value", 64'(rdata), 64'h01);
        rdchk("R9 pctl locked", 3'd3);
        rdchk("R9 lo locked", 3'd4);
        chk("R9 lo value", 64'(rdata), 64'h1234_5678);
        rdchk("R9 hi locked", 3'd5);
        wr(3'd2, 32'd1);
        cfg_addr = 3'd2; #1;
        chk("R10 inj set", 64'(rdata), 64'd1);
        @(negedge clk); #1;
        chk("R10 inj clear", 64'(rdata), 64'd0);
        repeat (8) @(negedge clk);
        rand_rdy = 1;
        repeat (4) begin
            wr(3'd2, 32'd1);
            repeat (9) @(negedge clk);
        end
        rand_rdy = 0;
        repeat (5) @(negedge clk);
        wr(3'd0, 32'd0);
        repeat (3) @(negedge clk);
        wr(3'd1, 32'h02);
        rdchk("R9 sel after disable", 3'd1);
        chk("R9 sel new", 64'(rdata), 64'h02);

        cmp_on = 0;
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule